// File: doc/BRIEF.md
# Transmit Rate-Adaptation Word Replicator

This block carries lower Ethernet speeds over a 32-bit word stream that runs at the 10G word rate. It takes packets one 32-bit beat at a time, with a valid/ready handshake. A packet's first beat also carries a user-chosen preamble word, supplied out of band. For each packet the block first emits that preamble word and then each payload word. Every word is repeated back to back by a factor set by the active link speed. A 10G link uses each word once. A 10M link repeats each word a thousand times.

The speed comes from one of two 3-bit inputs. One holds the result of auto-negotiation. The other is a direct setting that is used while bypass is high. The speed is captured when a packet's first beat is accepted and is held until that packet has been sent. The output marks the first copy of the preamble word as the start of the frame. It marks the final copy of the last payload word as the terminate, and gives that word's byte count.

Top module: `tx_rate_replicator`

## Requirements
- R1: After reset, o_valid is low and s_ready is high.
- R2: The repeat factor for rate code 0, 1, 2, 3, 4 and 5 is 1, 2, 4, 10, 100 and 1000 respectively (10G, 5G, 2.5G, 1G, 100M, 10M). Codes 6 and 7 give a factor of 1.
- R3: While bypass is high, the rate code is taken from rate_cfg. While bypass is low, it is taken from an_rate.
- R4: A frame starts with the s_pre value of its first beat. That value is output factor times in a row, and o_start is high on its first copy only.
- R5: Each payload word is output factor times in a row with o_valid high, in the order the beats were accepted.
- R6: o_term is high only on the final copy of the word whose beat had s_last set. On that copy o_bytes equals that beat's s_bytes (0 means four bytes). On every other cycle o_bytes is 0.
- R7: During a frame, s_ready is high only in the cycle that outputs the final copy of a payload word. It is never high while preamble copies are output, so each beat is taken exactly once.
- R8: The rate code is sampled when a first beat is accepted. Changes to bypass, rate_cfg or an_rate during the frame do not change its factor.
- R9: Between frames, a beat without s_first is accepted and dropped, and produces no output.
- R10: If the next payload beat is not offered when it is needed, o_valid stays low and s_ready stays high until the beat arrives. No extra copies are output.
- R11: A new frame's first beat may be accepted in the final copy cycle of the previous frame. Its preamble then follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Use rate_cfg instead of the negotiated rate |
| rate_cfg | input | 3 | Directly set rate code |
| an_rate | input | 3 | Negotiated rate code |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat taken this cycle |
| s_data | input | 32 | Input payload word |
| s_first | input | 1 | Beat is a frame's first |
| s_last | input | 1 | Beat is a frame's last |
| s_bytes | input | 2 | Valid bytes of the last beat, 0 = four |
| s_pre | input | 32 | Preamble word, read with the first beat |
| o_valid | output | 1 | Output word valid |
| o_data | output | 32 | Output word |
| o_start | output | 1 | First copy of the preamble word |
| o_term | output | 1 | Final copy of the last payload word |
| o_bytes | output | 2 | Valid bytes on the terminate copy, else 0 |

## Verification
The hardest case to reach is a rate change that arrives inside a frame at a slow rate. It has to happen after the first beat has been accepted and while hundreds of copies of a word are still pending. Only then does an early-sampling or late-sampling fault change the output. The bench changes rate_cfg in the cycle right after the first-beat handshake and predicts the frame at the rate that was in force when that beat was taken. Source gaps longer than the remaining copies force the waiting state. Back-to-back frames make the terminate cycle and the next first-beat handshake fall on the same clock.

// File: rtl/tx_rate_replicator.sv
module tx_rate_replicator #(
  parameter int DW = 32,
  parameter int CW = 10,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass,
  input  logic [2:0]    rate_cfg,
  input  logic [2:0]    an_rate,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_first,
  input  logic          s_last,
  input  logic [BW-1:0] s_bytes,
  input  logic [DW-1:0] s_pre,
  output logic          o_valid,
  output logic [DW-1:0] o_data,
  output logic          o_start,
  output logic          o_term,
  output logic [BW-1:0] o_bytes
);
  localparam logic [1:0] IDLE = 2'd0, PRE = 2'd1, DATA = 2'd2, WAIT = 2'd3;

  function automatic logic [CW-1:0] factor(input logic [2:0] code);
    case (code)
      3'd1:    factor = CW'(2);
      3'd2:    factor = CW'(4);
      3'd3:    factor = CW'(10);
      3'd4:    factor = CW'(100);
      3'd5:    factor = CW'(1000);
      default: factor = CW'(1);
    endcase
  endfunction

  logic [1:0]    phase;
  logic [CW-1:0] cnt, fac;
  logic [DW-1:0] pre_q, word_q;
  logic          last_q;
  logic [BW-1:0] bytes_q;

  wire [2:0] rate_sel   = bypass ? rate_cfg : an_rate;
  wire       at_end     = (cnt == fac - 1'b1);
  wire       frame_open = (phase == WAIT) || (phase == DATA && !last_q);
  wire       take       = s_valid && s_ready;

  assign s_ready = (phase == IDLE) || (phase == WAIT) || (phase == DATA && at_end);
  assign o_valid = (phase == PRE) || (phase == DATA);
  assign o_data  = (phase == PRE) ? pre_q : word_q;
  assign o_start = (phase == PRE) && (cnt == '0);
  assign o_term  = (phase == DATA) && last_q && at_end;
  assign o_bytes = o_term ? bytes_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= IDLE;
      cnt     <= '0;
      fac     <= CW'(1);
      pre_q   <= '0;
      word_q  <= '0;
      last_q  <= 1'b0;
      bytes_q <= '0;
    end else if (take && frame_open) begin
      word_q  <= s_data;
      last_q  <= s_last;
      bytes_q <= s_bytes;
      cnt     <= '0;
      phase   <= DATA;
    end else if (take && s_first) begin
      pre_q   <= s_pre;
      word_q  <= s_data;
      last_q  <= s_last;
      bytes_q <= s_bytes;
      fac     <= factor(rate_sel);
      cnt     <= '0;
      phase   <= PRE;
    end else if (take) begin
      cnt     <= '0;
      phase   <= IDLE;
    end else if (phase == PRE) begin
      if (at_end) begin
        cnt   <= '0;
        phase <= DATA;
      end else begin
        cnt   <= cnt + 1'b1;
      end
    end else if (phase == DATA) begin
      if (at_end) begin
        cnt   <= '0;
        phase <= last_q ? IDLE : WAIT;
      end else begin
        cnt   <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_rate_replicator_chk.sv
module tx_rate_replicator_chk #(
  parameter int DW = 32,
  parameter int CW = 10,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          o_valid,
  input logic [DW-1:0] o_data,
  input logic          o_start,
  input logic          o_term,
  input logic [BW-1:0] o_bytes,
  input logic [1:0]    phase,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] fac
);
  p_start_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    o_start |-> (o_valid && !s_ready));

  p_bytes_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_bytes != '0) |-> o_term);

  p_term_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    o_term |-> s_ready);

  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && $past(phase) == 2'd2 && !$past(s_ready)) |-> $stable(o_data));

  p_rate_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) != 2'd0 && !$past(s_valid && s_ready)) |-> $stable(fac));

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (cnt < fac));

  p_wait_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'd3 && !$past(s_valid)) |-> !o_valid);
endmodule

bind tx_rate_replicator tx_rate_replicator_chk #(.DW(DW), .CW(CW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .o_valid(o_valid), .o_data(o_data), .o_start(o_start), .o_term(o_term),
  .o_bytes(o_bytes), .phase(phase), .cnt(cnt), .fac(fac)
);

// File: tb/tx_rate_replicator_tb.sv
module tx_rate_replicator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass = 1'b1;
  logic [2:0]  rate_cfg = 3'd0, an_rate = 3'd0;
  logic        s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
  logic [31:0] s_data = '0, s_pre = '0;
  logic [1:0]  s_bytes = '0;
  logic        s_ready, o_valid, o_start, o_term;
  logic [31:0] o_data;
  logic [1:0]  o_bytes;

  always #10 clk = ~clk;

  tx_rate_replicator u_dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .rate_cfg(rate_cfg), .an_rate(an_rate),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_first(s_first),
    .s_last(s_last), .s_bytes(s_bytes), .s_pre(s_pre), .o_valid(o_valid),
    .o_data(o_data), .o_start(o_start), .o_term(o_term), .o_bytes(o_bytes)
  );

  typedef struct {
    logic [31:0] d;
    logic        st, te, lc;
    logic [1:0]  by;
    int          rq;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_err = 0, seq = 0;
  bit   done = 1'b0;

  task automatic chk(bit ok, int rq, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic int fac_of(logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 10;
      3'd4: return 100;
      3'd5: return 1000;
      default: return 1;
    endcase
  endfunction

  // Reference stream compared every clock
  always @(negedge clk) begin
    if (rst_n && !done && o_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, 9, "output with nothing expected", o_data, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(o_data == e.d && o_start == e.st && o_term == e.te && o_bytes == e.by,
            e.rq, "word/start/term/bytes", {o_start, o_term, o_bytes, o_data[27:0]},
            {e.st, e.te, e.by, e.d[27:0]});
        chk(s_ready == e.lc, 7, "ready on copy", {31'h0, s_ready}, {31'h0, e.lc});
      end
    end
  end

  task automatic send_frame(int n, logic [1:0] by, int rq, int gap, bit chg);
    int f;
    logic [31:0] pre;
    f = fac_of(bypass ? rate_cfg : an_rate);
    seq++;
    pre = 32'hA500_0000 + 32'(seq);
    for (int k = 0; k < f; k++) q.push_back('{pre, k == 0, 1'b0, 1'b0, 2'b0, rq});
    for (int i = 0; i < n; i++)
      for (int k = 0; k < f; k++) begin
        bit t;
        t = (i == n - 1) && (k == f - 1);
        q.push_back('{32'(seq * 256 + i), 1'b0, t, k == f - 1, t ? by : 2'b0, rq});
      end
    for (int i = 0; i < n; i++) begin
      s_data  = 32'(seq * 256 + i);
      s_first = (i == 0);
      s_last  = (i == n - 1);
      s_bytes = by;
      s_pre   = pre;
      s_valid = 1'b1;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
      if (i == 0 && chg) rate_cfg = 3'd0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(q.size() == 0, 5, "expected words left", 32'(q.size()), 32'h0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(o_valid == 1'b0, 1, "o_valid in reset", {31'h0, o_valid}, 32'h0);
    chk(s_ready == 1'b1, 1, "s_ready in reset", {31'h0, s_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(o_valid == 1'b0 && s_ready == 1'b1, 1, "after reset", {30'h0, o_valid, s_ready}, 32'h1);

    // R2 every code, back to back (R11)
    bypass = 1'b1;
    for (int c = 0; c < 8; c++) begin
      rate_cfg = 3'(c);
      send_frame(3, 2'(c), 2, 0, 1'b0);
    end
    drain();

    // R3 negotiated rate used when bypass is low
    bypass = 1'b0; rate_cfg = 3'd5; an_rate = 3'd3;
    send_frame(2, 2'd1, 3, 0, 1'b0);
    an_rate = 3'd1;
    send_frame(4, 2'd0, 3, 0, 1'b0);
    drain();

    // R8 rate change inside a frame is ignored
    bypass = 1'b1; rate_cfg = 3'd4;
    send_frame(3, 2'd2, 8, 0, 1'b1);
    send_frame(2, 2'd3, 8, 0, 1'b0);
    drain();

    // R10 source gaps longer than the copies left
    rate_cfg = 3'd0;
    send_frame(4, 2'd1, 10, 3, 1'b0);
    rate_cfg = 3'd1;
    send_frame(3, 2'd2, 10, 5, 1'b0);
    drain();

    // R11 back-to-back frames, R4/R6 single-word frame
    rate_cfg = 3'd2;
    send_frame(2, 2'd3, 11, 0, 1'b0);
    send_frame(1, 2'd3, 6, 0, 1'b0);
    send_frame(2, 2'd1, 11, 0, 1'b0);
    drain();

    // R9 stray beat between frames
    s_data = 32'hDEAD_BEEF; s_first = 1'b0; s_last = 1'b0; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk(o_valid == 1'b0 && s_ready == 1'b1, 9, "stray beat output", {30'h0, o_valid, s_ready}, 32'h1);
    end
    rate_cfg = 3'd3;
    send_frame(2, 2'd2, 4, 0, 1'b0);
    drain();

    finish_run();
  end
endmodule